// File: doc/BRIEF.md
# Freezable Event Counter Monitor

This block watches a set of single-cycle event lines and counts them in several 32-bit event counters, next to one 64-bit cycle counter that advances on every clock. Every counter, the global control register and one local control register per counter sit on a simple 32-bit register bus. Writes take effect at the clock edge and reads are combinational. Software picks which event line each counter watches, freezes counters one at a time or all together, and loads or clears any counter at any time.

A counter overflows when counting moves its most significant bit from 0 to 1. If the overflow is enabled at both the global and the local level, the block raises a level interrupt. In the same clock edge it sets the global freeze bit, so every counter stops on the value it held when the overflow was detected. Software reads the counters, clears the MSB of each counter that overflowed, and clears the freeze bit to resume counting. Event lines are assumed to be synchronous to `clk`, and each line counts once per cycle in which it is high.

Top module: `evmon_top`

## Requirements
- R1: After a synchronous active-low reset, every counter reads 0, every local control register reads 0, the global control register reads 0x1 (only the freeze-all bit set) and `irq` is 0.
- R2: While the global freeze-all bit (global control bit 0) is 1, no counter changes except through a bus write.
- R3: An event counter advances by exactly 1 on each clock edge at which the event line picked by its select field is high, provided that both its local freeze bit and the global freeze-all bit are 0. A select value of EVT_LINES or above never counts.
- R4: The cycle counter advances by 1 on every clock edge at which the global freeze-all bit and its own local freeze bit are both 0, and it carries from its low word (0x080) into its high word (0x084).
- R5: A bus write to a counter, including a write to either word of the cycle counter, replaces that counter's value in that clock edge, and the increment due in the same edge is dropped.
- R6: An overflow is an MSB transition from 0 to 1 caused by counting. It raises `irq` only when the interrupt enable (global bit 1), the freeze-on-condition enable (global bit 2) and the counter's condition enable (local bit 1) are all 1. Otherwise it neither raises `irq` nor sets the freeze-all bit.
- R7: A qualified overflow sets the global freeze-all bit in the same edge at which the counter's MSB becomes 1, so every counter holds its value from then on. A software write that arrives in that same edge does not override this.
- R8: `irq` is a level that stays 1 until every overflowed counter whose condition enable is 1 has had its MSB cleared by a bus write. Clearing the freeze-all bit alone does not lower it.
- R9: The register map uses word addresses: global control at 0x000, cycle-counter local control at 0x01C, event-counter n local control at 0x020+4n (bit 0 freeze, bit 1 condition enable, bits 15:8 event select), cycle counter at 0x080/0x084 and event counter n at 0x100+4n. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_in | input | EVT_LINES | Event lines, one count per cycle high |
| bus_addr | input | ADDR_W | Register byte address (word aligned) |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Overflow interrupt level |

## Verification
The event lines are swept through all 256 patterns of an 8-line configuration and then through a walking-one pattern. The counter selects are set to the lowest line, a middle line, the top line and an out-of-range value. This shows that each counter samples only its own line and that an out-of-range select never counts. The same stimulus is repeated under a local freeze and under the global freeze, which separates the two freeze paths. Loaded values just below the MSB, tried with each enable missing in turn, show which combinations raise the interrupt. A write issued while the selected line is high tells write priority apart from increment. A low word preloaded near its maximum exposes the carry into the high word of the cycle counter.

// File: rtl/evmon_pkg.sv
// Package evmon_pkg: register map, control bit positions and the local
// control record shared by the monitor modules.
// Assumes a 32-bit data bus and word-aligned byte addresses.
package evmon_pkg;
    localparam int SEL_W       = 8;
    localparam int A_GCTL      = 'h000;
    localparam int A_CYC_LCTL  = 'h01C;
    localparam int A_LCTL_BASE = 'h020;
    localparam int A_CYC_BASE  = 'h080;
    localparam int A_EVC_BASE  = 'h100;
    localparam int G_FRZ       = 0;
    localparam int G_IRQEN     = 1;
    localparam int G_FCE       = 2;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             ce;
        logic             frz;
    } lctl_t;

    // Pack a local control record into its bus word.
    function automatic logic [31:0] lctl_word(input lctl_t l);
        return {16'b0, l.sel, 6'b0, l.ce, l.frz};
    endfunction

    // Unpack a bus word into a local control record.
    function automatic lctl_t lctl_from(input logic [31:0] w);
        lctl_t l;
        l.sel = w[15:8];
        l.ce  = w[1];
        l.frz = w[0];
        return l;
    endfunction
endpackage

// File: rtl/evmon_ctrl.sv
// Module evmon_ctrl: global control register (freeze-all, interrupt enable,
// freeze-on-condition enable), automatic freeze on a qualified overflow and
// the level interrupt.
// Assumes trig bits are single-cycle overflow pulses already gated by the
// counters' own condition enables.
module evmon_ctrl #(
    parameter int NCNT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gctl_wen,
    input  logic [31:0]     wdata,
    input  logic [NCNT-1:0] trig,
    input  logic [NCNT-1:0] ovf_flag,
    input  logic [NCNT-1:0] ce_vec,
    output logic            run_g,
    output logic [31:0]     gctl_q,
    output logic            irq
);
    import evmon_pkg::*;

    logic frz_q, ie_q, fce_q;
    logic arm, fire;

    assign arm  = ie_q & fce_q;
    assign fire = arm & (|trig);

    // Global control register; a qualified overflow forces freeze-all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_q <= 1'b1;
            ie_q  <= 1'b0;
            fce_q <= 1'b0;
        end else begin
            if (gctl_wen) begin
                frz_q <= wdata[G_FRZ];
                ie_q  <= wdata[G_IRQEN];
                fce_q <= wdata[G_FCE];
            end
            if (fire) begin
                frz_q <= 1'b1;
            end
        end
    end

    // Outputs: run permission, read-back word and interrupt level.
    always_comb begin
        run_g  = ~frz_q;
        gctl_q = 32'(frz_q) << G_FRZ;
        gctl_q = gctl_q | (32'(ie_q) << G_IRQEN) | (32'(fce_q) << G_FCE);
        irq    = arm & (|(ovf_flag & ce_vec));
    end

    p_fire_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> frz_q);
    p_wr_sets_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gctl_wen && !fire) |=> (frz_q == $past(wdata[G_FRZ])) && (ie_q == $past(wdata[G_IRQEN])));
endmodule

// File: rtl/evmon_evcnt.sv
// Module evmon_evcnt: one event counter with its local control register.
// Counts one per cycle that the selected event line is high while both
// freeze conditions are clear; a bus write wins over the increment.
// Assumes CNT_W <= 32 and EVT_LINES <= 2**SEL_W.
module evmon_evcnt #(
    parameter int EVT_LINES = 8,
    parameter int CNT_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_LINES-1:0] ev_in,
    input  logic                 run_g,
    input  logic                 lctl_wen,
    input  logic                 cnt_wen,
    input  logic [31:0]          wdata,
    output logic [31:0]          lctl_q,
    output logic [31:0]          cnt_rd,
    output logic                 ce,
    output logic                 ovf_pulse,
    output logic                 ovf_q
);
    import evmon_pkg::*;

    localparam int PADW = 2 ** SEL_W;
    localparam logic [CNT_W-1:0] MAXPOS = {1'b0, {(CNT_W-1){1'b1}}};

    lctl_t            lc;
    logic [CNT_W-1:0] cnt_q;
    logic [PADW-1:0]  ev_pad;
    logic             hit, adv;

    assign ev_pad = PADW'(ev_in);

    // Event selection and advance decision.
    always_comb begin
        hit       = ev_pad[lc.sel];
        adv       = run_g & ~lc.frz & hit & ~cnt_wen;
        ovf_pulse = adv & (cnt_q == MAXPOS);
        lctl_q    = lctl_word(lc);
        cnt_rd    = 32'(cnt_q);
        ce        = lc.ce;
    end

    // Local control register.
    always_ff @(posedge clk) begin
        if (!rst_n)        lc <= '0;
        else if (lctl_wen) lc <= lctl_from(wdata);
    end

    // Counter with write priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_wen) cnt_q <= wdata[CNT_W-1:0];
        else if (adv)     cnt_q <= cnt_q + 1'b1;
    end

    // Sticky overflow flag, cleared by a write that clears the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ovf_q <= 1'b0;
        else if (cnt_wen && !wdata[CNT_W-1])   ovf_q <= 1'b0;
        else if (ovf_pulse)                    ovf_q <= 1'b1;
    end

    p_hold_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((!run_g || lc.frz) && !cnt_wen) |=> $stable(cnt_q));
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_g && !lc.frz && hit && !cnt_wen) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wen |=> (cnt_q == $past(wdata[CNT_W-1:0])));
    p_ovf_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> (cnt_q[CNT_W-1] && ovf_q));
endmodule

// File: rtl/evmon_cyccnt.sv
// Module evmon_cyccnt: free-running cycle counter split into 32-bit bus words,
// with a local control register (freeze and condition enable only).
// Assumes CYC_W is a multiple of 32; a write to any word drops the increment.
module evmon_cyccnt #(
    parameter int CYC_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_g,
    input  logic                   lctl_wen,
    input  logic [CYC_W/32-1:0]    cnt_wen,
    input  logic [31:0]            wdata,
    output logic [31:0]            lctl_q,
    output logic [CYC_W-1:0]       cnt_q,
    output logic                   ce,
    output logic                   ovf_pulse,
    output logic                   ovf_q
);
    import evmon_pkg::*;

    localparam int WORDS = CYC_W / 32;
    localparam logic [CYC_W-1:0] MAXPOS = {1'b0, {(CYC_W-1){1'b1}}};

    lctl_t            lc;
    logic [CYC_W-1:0] nxt;
    logic             adv;

    // Next value: word writes first, otherwise the increment.
    always_comb begin
        adv       = run_g & ~lc.frz & ~(|cnt_wen);
        ovf_pulse = adv & (cnt_q == MAXPOS);
        nxt       = cnt_q;
        for (int w = 0; w < WORDS; w++) begin
            if (cnt_wen[w]) nxt[w*32 +: 32] = wdata;
        end
        if (adv) nxt = cnt_q + 1'b1;
        lctl_q = lctl_word('{sel: '0, ce: lc.ce, frz: lc.frz});
        ce     = lc.ce;
    end

    // Local control register (select field unused).
    always_ff @(posedge clk) begin
        if (!rst_n)        lc <= '0;
        else if (lctl_wen) lc <= '{sel: '0, ce: wdata[1], frz: wdata[0]};
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= nxt;
    end

    // Sticky overflow flag, cleared by a top-word write with MSB 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                                ovf_q <= 1'b0;
        else if (cnt_wen[WORDS-1] && !wdata[31])   ovf_q <= 1'b0;
        else if (ovf_pulse)                        ovf_q <= 1'b1;
    end

    p_cyc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_g && !lc.frz && cnt_wen == '0) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_cyc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_g && cnt_wen == '0) |=> $stable(cnt_q));
endmodule

// File: rtl/evmon_top.sv
// Module evmon_top: event counter monitor. Decodes the register bus, holds
// NUM_EVT event counters and one cycle counter, and raises a level interrupt
// that also freezes all counting on a qualified MSB overflow.
// Assumes NUM_EVT <= 24 so local control words stay below the cycle counter.
module evmon_top #(
    parameter int NUM_EVT   = 4,
    parameter int EVT_LINES = 8,
    parameter int EVT_W     = 32,
    parameter int CYC_W     = 64,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_LINES-1:0] ev_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wen,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 irq
);
    import evmon_pkg::*;

    localparam int NCNT  = NUM_EVT + 1;
    localparam int WORDS = CYC_W / 32;

    logic                 run_g;
    logic [31:0]          gctl_q;
    logic                 gctl_wen;
    logic [NUM_EVT-1:0]   ev_lwen, ev_cwen;
    logic [WORDS-1:0]     cyc_cwen;
    logic                 cyc_lwen;
    logic [31:0]          ev_lq [NUM_EVT];
    logic [31:0]          ev_cq [NUM_EVT];
    logic [31:0]          cyc_lq;
    logic [CYC_W-1:0]     cyc_q;
    logic [NCNT-1:0]      ce_vec, pulse_vec, flag_vec;

    // Write decode for every register.
    always_comb begin
        gctl_wen = bus_wen && (bus_addr == ADDR_W'(A_GCTL));
        cyc_lwen = bus_wen && (bus_addr == ADDR_W'(A_CYC_LCTL));
        for (int n = 0; n < NUM_EVT; n++) begin
            ev_lwen[n] = bus_wen && (bus_addr == ADDR_W'(A_LCTL_BASE + 4 * n));
            ev_cwen[n] = bus_wen && (bus_addr == ADDR_W'(A_EVC_BASE + 4 * n));
        end
        for (int w = 0; w < WORDS; w++) begin
            cyc_cwen[w] = bus_wen && (bus_addr == ADDR_W'(A_CYC_BASE + 4 * w));
        end
    end

    // Combinational read mux; unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_GCTL))     bus_rdata = gctl_q;
        if (bus_addr == ADDR_W'(A_CYC_LCTL)) bus_rdata = cyc_lq;
        for (int n = 0; n < NUM_EVT; n++) begin
            if (bus_addr == ADDR_W'(A_LCTL_BASE + 4 * n)) bus_rdata = ev_lq[n];
            if (bus_addr == ADDR_W'(A_EVC_BASE + 4 * n))  bus_rdata = ev_cq[n];
        end
        for (int w = 0; w < WORDS; w++) begin
            if (bus_addr == ADDR_W'(A_CYC_BASE + 4 * w)) bus_rdata = cyc_q[w*32 +: 32];
        end
    end

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evc
        evmon_evcnt #(
            .EVT_LINES(EVT_LINES),
            .CNT_W    (EVT_W)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_in    (ev_in),
            .run_g    (run_g),
            .lctl_wen (ev_lwen[g]),
            .cnt_wen  (ev_cwen[g]),
            .wdata    (bus_wdata),
            .lctl_q   (ev_lq[g]),
            .cnt_rd   (ev_cq[g]),
            .ce       (ce_vec[g]),
            .ovf_pulse(pulse_vec[g]),
            .ovf_q    (flag_vec[g])
        );
    end

    evmon_cyccnt #(
        .CYC_W(CYC_W)
    ) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_g    (run_g),
        .lctl_wen (cyc_lwen),
        .cnt_wen  (cyc_cwen),
        .wdata    (bus_wdata),
        .lctl_q   (cyc_lq),
        .cnt_q    (cyc_q),
        .ce       (ce_vec[NUM_EVT]),
        .ovf_pulse(pulse_vec[NUM_EVT]),
        .ovf_q    (flag_vec[NUM_EVT])
    );

    evmon_ctrl #(
        .NCNT(NCNT)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .gctl_wen(gctl_wen),
        .wdata   (bus_wdata),
        .trig    (pulse_vec & ce_vec),
        .ovf_flag(flag_vec),
        .ce_vec  (ce_vec),
        .run_g   (run_g),
        .gctl_q  (gctl_q),
        .irq     (irq)
    );

    p_irq_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gctl_q[G_IRQEN] || !gctl_q[G_FCE]) |-> !irq);
    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wen) |=> irq);
endmodule

// File: tb/evmon_top_tb.sv
// Bench evmon_top_tb_top: sweeps event patterns over a 4-counter, 8-line
// configuration against an arithmetic model kept in the bench, then drives
// the overflow, interrupt and freeze corner cases.
module evmon_top_tb_top;
    localparam int NUM    = 4;
    localparam int LINES  = 8;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LINES-1:0]  ev_in = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wen = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_ev [NUM];
    logic [63:0] m_cyc;
    logic        m_gfrz;
    logic        m_lfrz [NUM+1];
    logic [7:0]  m_sel [NUM];

    evmon_top #(
        .NUM_EVT  (NUM),
        .EVT_LINES(LINES),
        .ADDR_W   (ADDR_W)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_in    (ev_in),
        .bus_addr (bus_addr),
        .bus_wen  (bus_wen),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = ADDR_W'(a);
        #1;
        d = bus_rdata;
    endtask

    // Model of one clock edge of counting, using pre-edge state.
    task automatic model_step();
        if (!m_gfrz) begin
            if (!m_lfrz[NUM]) m_cyc = m_cyc + 1;
            for (int n = 0; n < NUM; n++) begin
                int idx = int'(m_sel[n]);
                if (!m_lfrz[n] && idx < LINES && ev_in[idx]) m_ev[n] = m_ev[n] + 1;
            end
        end
    endtask

    task automatic apply_write(input int a, input logic [31:0] d, input logic [63:0] pre);
        if (a == 'h000) m_gfrz = d[0];
        if (a == 'h01C) m_lfrz[NUM] = d[0];
        if (a == 'h080) m_cyc = {pre[63:32], d};
        if (a == 'h084) m_cyc = {d, pre[31:0]};
        for (int n = 0; n < NUM; n++) begin
            if (a == 'h020 + 4 * n) begin
                m_lfrz[n] = d[0];
                m_sel[n]  = d[15:8];
            end
            if (a == 'h100 + 4 * n) m_ev[n] = d;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        logic [63:0] pre;
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(posedge clk);
        pre = m_cyc;
        model_step();
        apply_write(a, d, pre);
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v, h;
        for (int n = 0; n < NUM; n++) begin
            rd('h100 + 4 * n, v);
            chk($sformatf("%s counter%0d", tag, n), 64'(v), 64'(m_ev[n]));
        end
        rd('h080, v);
        rd('h084, h);
        chk($sformatf("%s cycle", tag), {h, v}, m_cyc);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, c0, cy;
        for (int n = 0; n < NUM; n++) begin
            m_ev[n] = '0; m_lfrz[n] = 1'b0; m_sel[n] = '0;
        end
        m_lfrz[NUM] = 1'b0;
        m_cyc  = '0;
        m_gfrz = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd('h000, v); chk("R1 global ctrl", 64'(v), 64'h1);
        rd('h020, v); chk("R1 local ctrl0", 64'(v), 64'h0);
        chk("R1 irq", 64'(irq), 64'h0);
        check_all("R1 reset");

        // R2: configure and drive events while frozen
        wr('h020, 32'h0000_0000);
        wr('h024, 32'h0000_0300);
        wr('h028, 32'h0000_0700);
        wr('h02C, 32'h0000_0900);
        ev_in = '1;
        repeat (10) tick();
        check_all("R2 frozen after reset");
        rd('h028, v); chk("R9 local ctrl2 readback", 64'(v), 64'h700);

        // R3: exhaustive sweep of event patterns
        wr('h000, 32'h0);
        for (int p = 0; p < 256; p++) begin
            ev_in = LINES'(p);
            tick();
        end
        check_all("R3 full sweep");
        for (int t = 0; t < 16; t++) begin
            ev_in = LINES'(1 << (t % LINES));
            tick();
        end
        check_all("R3 walking one");

        // R3: local freeze of counter1
        wr('h024, 32'h0000_0301);
        ev_in = '1;
        repeat (20) tick();
        check_all("R3 local freeze");
        wr('h024, 32'h0000_0300);

        // R4: carry from low into high word
        wr('h080, 32'hFFFF_FFF0);
        wr('h084, 32'h0);
        repeat (30) tick();
        check_all("R4 carry");
        rd('h084, v); chk("R4 high word", 64'(v), 64'h1);

        // R5: write beats increment on a busy line
        ev_in = '1;
        wr('h100, 32'h0000_1234);
        rd('h100, v); chk("R5 write priority", 64'(v), 64'h1234);
        tick();
        rd('h100, v); chk("R5 count after write", 64'(v), 64'h1235);

        // R2: freeze-all while running
        wr('h000, 32'h1);
        for (int t = 0; t < 10; t++) begin
            ev_in = LINES'(t * 37);
            tick();
        end
        check_all("R2 frozen while running");

        // R6: overflow without freeze-on-condition enable
        ev_in = '0;
        wr('h000, 32'h2);
        wr('h020, 32'h0000_0002);
        wr('h100, 32'h7FFF_FFFE);
        ev_in = 8'h01;
        repeat (4) tick();
        check_all("R6 unqualified");
        chk("R6 irq without fce", 64'(irq), 64'h0);
        rd('h000, v); chk("R6 no freeze without fce", 64'(v), 64'h2);
        ev_in = '0;
        wr('h100, 32'h0);

        // R6: overflow with condition enable off
        wr('h000, 32'h6);
        wr('h104, 32'h7FFF_FFFF);
        ev_in = 8'h08;
        repeat (2) tick();
        ev_in = '0;
        chk("R6 irq with ce off", 64'(irq), 64'h0);
        rd('h000, v); chk("R6 no freeze with ce off", 64'(v), 64'h6);
        rd('h104, v); chk("R6 counter1 passed msb", 64'(v), 64'h8000_0001);

        // R6/R7: qualified overflow on counter2
        wr('h028, 32'h0000_0702);
        wr('h108, 32'h7FFF_FFFD);
        ev_in = '1;
        repeat (5) tick();
        rd('h108, v); chk("R7 counter2 held at msb", 64'(v), 64'h8000_0000);
        rd('h000, v); chk("R7 freeze-all set", 64'(v), 64'h7);
        chk("R6 irq qualified", 64'(irq), 64'h1);
        rd('h100, c0);
        rd('h080, cy);
        repeat (10) tick();
        rd('h100, v); chk("R7 counter0 held", 64'(v), 64'(c0));
        rd('h080, v); chk("R7 cycle held", 64'(v), 64'(cy));

        // R8: clearing freeze alone keeps irq; clearing msb drops it
        wr('h000, 32'h6);
        chk("R8 irq after freeze clear", 64'(irq), 64'h1);
        repeat (3) tick();
        rd('h108, v); chk("R3 counter2 resumed", 64'(v), 64'h8000_0003);
        wr('h108, 32'h5);
        chk("R8 irq after msb clear", 64'(irq), 64'h0);
        rd('h000, v); chk("R8 no refreeze", 64'(v), 64'h6);

        // R9: unmapped address
        rd('h0F0, v); chk("R9 unmapped read", 64'(v), 64'h0);

        finish_run();
    end
endmodule